// File: doc/BRIEF.md
# Direct-Mapped TLB Translation Unit

This unit turns a virtual address into a physical address for one access at a time, either an instruction fetch or a data load/store. It holds two separate direct-mapped translation tables, one for each side, and each slot of a table holds a match word and a translate word. A lookup picks one slot from the low bits of the virtual page number. It compares the stored page number and valid flag, then checks the permission bits that belong to the current privilege mode. On a hit it returns the translated address. On any failure it reports one exception class.

Each side has its own enable input. When the enable for the side of the access is clear, the address passes through unchanged and every right is granted. The request is registered on a clock edge and the lookup works combinationally from that register, so the response is present during the following cycle. On a fault the unit records the faulting virtual address in an error-address register and pulses a signal that cancels any pending load-linked reservation. Software fills the tables through a single write port.

Top module: `tlb_xlate_unit`

## Requirements
- R1: Reset clears every valid flag in both tables and sets err_addr to 0. While reset is held and in the first cycle after it, rsp_valid and rsv_cancel are 0. After reset, a lookup of a slot that was valid before the reset faults and does not hit.
- R2: A request sampled on a rising edge with req_valid high produces rsp_valid high for exactly the following cycle. With req_valid low, rsp_valid stays low. In every valid response exactly one of rsp_hit and rsp_fault is high.
- R3: The access type has bit 0 = write and bit 1 = instruction fetch. When imu_en (for fetches) or dmu_en (for loads/stores) is 0, the response is a hit with rsp_paddr equal to the virtual address and rsp_prot = 3'b111.
- R4: The page offset is the low 13 bits. The slot index is the low 6 bits of the virtual page number (address bits 31:13). If the stored page number differs from the full virtual page number, the response is a miss: rsp_exc = 1 for a fetch and 2 for a load/store.
- R5: Match word layout: bits 31:13 hold the page number and bit 0 holds the valid flag. If the tag matches but the valid flag is 0, the response is a page fault: rsp_exc = 3 for a fetch and 4 for a load/store.
- R6: In the instruction translate word, bit 6 grants execute in supervisor mode and bit 7 grants execute in user mode. Only the bit for the current mode (req_sup) counts. A fetch without that right gives rsp_exc = 3.
- R7: In the data translate word, bit 6 is supervisor read, bit 7 supervisor write, bit 8 user read and bit 9 user write. A read needs the mode's read bit and a write needs the mode's write bit. Otherwise rsp_exc = 4.
- R8: On a hit through a table, rsp_paddr is translate-word bits 31:13 followed by the 13 untouched offset bits of the virtual address. rsp_prot = {exec, write, read} holds the rights that the entry grants in the current mode. A hit has rsp_exc = 0.
- R9: A fill write on a rising edge is seen by a request registered on that same edge. fill_inst = 1 selects the instruction table and fill_xlate = 1 selects the translate word. A write changes only the addressed word of the addressed table.
- R10: During a faulting response rsv_cancel is 1, and otherwise it is 0. err_addr takes the faulting virtual address on the edge that ends the faulting response, and it holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address of the access |
| req_type | input | 2 | Access type: bit 0 write, bit 1 instruction fetch |
| req_sup | input | 1 | 1 = supervisor mode, 0 = user mode |
| imu_en | input | 1 | Instruction-side translation enable |
| dmu_en | input | 1 | Data-side translation enable |
| fill_en | input | 1 | Table write strobe |
| fill_inst | input | 1 | 1 = instruction table, 0 = data table |
| fill_xlate | input | 1 | 1 = translate word, 0 = match word |
| fill_idx | input | 6 | Slot to write |
| fill_data | input | 32 | Word written into the slot |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Translation raised an exception |
| rsp_exc | output | 3 | 0 none, 1 instruction miss, 2 data miss, 3 instruction page fault, 4 data page fault |
| rsp_paddr | output | 32 | Physical address |
| rsp_prot | output | 3 | Granted rights {exec, write, read} |
| err_addr | output | 32 | Last faulting virtual address |
| rsv_cancel | output | 1 | Cancel load-linked reservation |

## Verification
The bench places a second page number on the slot of a filled entry. A design that compares only the index bits would hit there, when it should report a miss. It also makes a tag-matching entry invalid. A design that confuses the two fault classes would then report a miss in place of a page fault. Permission tests vary mode and direction separately and use a slot with user read rights but no user write rights. This catches a design that reads the wrong mode's bit, or that checks read rights for a write. Other tests fill a data slot and fetch the same address from the instruction table, which catches cross-side writes. A fill issued on the same edge as the request catches a table that has an extra register stage. A fault followed by a hit catches an error-address register that keeps loading. A reset in mid-run shows whether stale valid flags survive.

// File: rtl/tlbx_pkg.sv
// Shared encodings for the TLB translation unit.
// Assumes: access type bit 0 = write, bit 1 = fetch; permission fields start at bit 6.
package tlbx_pkg;
    typedef enum logic [2:0] {
        EXC_NONE  = 3'd0,
        EXC_IMISS = 3'd1,
        EXC_DMISS = 3'd2,
        EXC_IPF   = 3'd3,
        EXC_DPF   = 3'd4
    } exc_e;

    localparam int ACC_WR_BIT    = 0;
    localparam int ACC_FETCH_BIT = 1;
    localparam int PERM_LSB      = 6;
    localparam int INST_PERM_W   = 2;
    localparam int DATA_PERM_W   = 4;
    localparam int PROT_W        = 3;
    localparam logic [PROT_W-1:0] PROT_ALL = 3'b111;
endpackage

// File: rtl/tlbx_req_reg.sv
// Request register: samples one translation request and the mode/enable
// state on each rising edge. Assumes the inputs are stable around the edge.
module tlbx_req_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_vaddr,
    input  logic [1:0]        in_type,
    input  logic              in_sup,
    input  logic              in_imu_en,
    input  logic              in_dmu_en,
    output logic              q_valid,
    output logic [ADDR_W-1:0] q_vaddr,
    output logic [1:0]        q_type,
    output logic              q_sup,
    output logic              q_imu_en,
    output logic              q_dmu_en
);
    // Capture the request each cycle; the valid flag clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid  <= 1'b0;
            q_vaddr  <= '0;
            q_type   <= '0;
            q_sup    <= 1'b0;
            q_imu_en <= 1'b0;
            q_dmu_en <= 1'b0;
        end else begin
            q_valid  <= in_valid;
            q_vaddr  <= in_vaddr;
            q_type   <= in_type;
            q_sup    <= in_sup;
            q_imu_en <= in_imu_en;
            q_dmu_en <= in_dmu_en;
        end
    end
endmodule

// File: rtl/tlbx_table.sv
// One direct-mapped translation table. Each slot holds a page-number tag, a
// valid flag, a page frame and PERM_W permission bits. Writes land on the edge
// and combinational lookups see them right after it. Assumes DEPTH is a power of two.
module tlbx_table
    import tlbx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13,
    parameter int DEPTH     = 64,
    parameter int PERM_W    = 2,
    localparam int VPN_W    = ADDR_W - PAGE_BITS,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_xlate,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] lk_vaddr,
    output logic              lk_tag_eq,
    output logic              lk_valid,
    output logic [VPN_W-1:0]  lk_pfn,
    output logic [PERM_W-1:0] lk_perm
);
    logic [VPN_W-1:0]  tag_mem  [DEPTH];
    logic [VPN_W-1:0]  pfn_mem  [DEPTH];
    logic [PERM_W-1:0] perm_mem [DEPTH];
    logic [DEPTH-1:0]  vld;
    logic [VPN_W-1:0]  lk_vpn;
    logic [IDX_W-1:0]  lk_idx;
    logic              unused_fill_bits;

    // Valid flags: cleared by reset, set from bit 0 of a match-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (wr_en && !wr_xlate) begin
            vld[wr_idx] <= wr_data[0];
        end
    end

    // Tag, frame and permission storage; no reset needed behind the valid flags.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_xlate) begin
                pfn_mem[wr_idx]  <= wr_data[ADDR_W-1:PAGE_BITS];
                perm_mem[wr_idx] <= wr_data[PERM_LSB +: PERM_W];
            end else begin
                tag_mem[wr_idx]  <= wr_data[ADDR_W-1:PAGE_BITS];
            end
        end
    end

    // Slot select and full page-number compare.
    always_comb begin
        lk_vpn    = lk_vaddr[ADDR_W-1:PAGE_BITS];
        lk_idx    = lk_vpn[IDX_W-1:0];
        lk_tag_eq = (tag_mem[lk_idx] == lk_vpn);
        lk_valid  = vld[lk_idx];
        lk_pfn    = pfn_mem[lk_idx];
        lk_perm   = perm_mem[lk_idx];
    end

    assign unused_fill_bits = ^{wr_data[PAGE_BITS-1:PERM_LSB+PERM_W],
                                wr_data[PERM_LSB-1:1], lk_vaddr[PAGE_BITS-1:0]};
endmodule

// File: rtl/tlbx_perm.sv
// Permission decode for one side. IS_INST=1: two execute bits (supervisor,
// user). IS_INST=0: supervisor read/write and user read/write. Produces the
// rights granted in the current mode and whether this access is allowed.
module tlbx_perm
    import tlbx_pkg::*;
#(
    parameter bit IS_INST = 1'b1,
    parameter int PERM_W  = 2
) (
    input  logic              sup,
    input  logic              is_write,
    input  logic [PERM_W-1:0] perm,
    output logic [PROT_W-1:0] prot,
    output logic              allow
);
    generate
        if (IS_INST) begin : g_inst
            logic x_ok;
            logic unused_dir;
            // Execute right for the current mode only.
            always_comb begin
                x_ok  = sup ? perm[0] : perm[1];
                prot  = {x_ok, 1'b0, 1'b0};
                allow = x_ok;
            end
            assign unused_dir = is_write;
        end else begin : g_data
            logic r_ok;
            logic w_ok;
            // Read and write rights for the mode, then pick by direction.
            always_comb begin
                r_ok  = sup ? perm[0] : perm[2];
                w_ok  = sup ? perm[1] : perm[3];
                prot  = {1'b0, w_ok, r_ok};
                allow = is_write ? w_ok : r_ok;
            end
        end
    endgenerate
endmodule

// File: rtl/tlb_xlate_unit.sv
// Top of the TLB translation unit: request register, instruction and data
// tables, per-side permission decode, fault classification and the
// error-address register. Response is valid the cycle after the request edge.
module tlb_xlate_unit
    import tlbx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13,
    parameter int DEPTH     = 64,
    localparam int VPN_W    = ADDR_W - PAGE_BITS,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_type,
    input  logic              req_sup,
    input  logic              imu_en,
    input  logic              dmu_en,
    input  logic              fill_en,
    input  logic              fill_inst,
    input  logic              fill_xlate,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [ADDR_W-1:0] fill_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic [2:0]        rsp_exc,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [PROT_W-1:0] rsp_prot,
    output logic [ADDR_W-1:0] err_addr,
    output logic              rsv_cancel
);
    logic              q_valid, q_sup, q_imu_en, q_dmu_en;
    logic [ADDR_W-1:0] q_vaddr;
    logic [1:0]        q_type;
    logic              is_fetch, is_write, side_ident;

    logic                   i_tag_eq, i_valid, d_tag_eq, d_valid;
    logic [VPN_W-1:0]       i_pfn, d_pfn;
    logic [INST_PERM_W-1:0] i_perm;
    logic [DATA_PERM_W-1:0] d_perm;
    logic [PROT_W-1:0]      i_prot, d_prot;
    logic                   i_allow, d_allow;

    logic              s_tag_eq, s_valid, s_allow;
    logic [VPN_W-1:0]  s_pfn;
    logic [PROT_W-1:0] s_prot;
    exc_e              exc;
    logic [ADDR_W-1:0] paddr;
    logic [PROT_W-1:0] prot;

    tlbx_req_reg #(.ADDR_W(ADDR_W)) u_req (
        .clk(clk), .rst_n(rst_n),
        .in_valid(req_valid), .in_vaddr(req_vaddr), .in_type(req_type),
        .in_sup(req_sup), .in_imu_en(imu_en), .in_dmu_en(dmu_en),
        .q_valid(q_valid), .q_vaddr(q_vaddr), .q_type(q_type),
        .q_sup(q_sup), .q_imu_en(q_imu_en), .q_dmu_en(q_dmu_en)
    );

    tlbx_table #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DEPTH(DEPTH),
                 .PERM_W(INST_PERM_W)) u_itab (
        .clk(clk), .rst_n(rst_n),
        .wr_en(fill_en && fill_inst), .wr_xlate(fill_xlate),
        .wr_idx(fill_idx), .wr_data(fill_data), .lk_vaddr(q_vaddr),
        .lk_tag_eq(i_tag_eq), .lk_valid(i_valid), .lk_pfn(i_pfn), .lk_perm(i_perm)
    );

    tlbx_table #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DEPTH(DEPTH),
                 .PERM_W(DATA_PERM_W)) u_dtab (
        .clk(clk), .rst_n(rst_n),
        .wr_en(fill_en && !fill_inst), .wr_xlate(fill_xlate),
        .wr_idx(fill_idx), .wr_data(fill_data), .lk_vaddr(q_vaddr),
        .lk_tag_eq(d_tag_eq), .lk_valid(d_valid), .lk_pfn(d_pfn), .lk_perm(d_perm)
    );

    tlbx_perm #(.IS_INST(1'b1), .PERM_W(INST_PERM_W)) u_iperm (
        .sup(q_sup), .is_write(is_write), .perm(i_perm),
        .prot(i_prot), .allow(i_allow)
    );

    tlbx_perm #(.IS_INST(1'b0), .PERM_W(DATA_PERM_W)) u_dperm (
        .sup(q_sup), .is_write(is_write), .perm(d_perm),
        .prot(d_prot), .allow(d_allow)
    );

    // Decode the registered access type and pick the side's results.
    always_comb begin
        is_fetch   = q_type[ACC_FETCH_BIT];
        is_write   = q_type[ACC_WR_BIT];
        side_ident = is_fetch ? !q_imu_en : !q_dmu_en;
        s_tag_eq   = is_fetch ? i_tag_eq : d_tag_eq;
        s_valid    = is_fetch ? i_valid  : d_valid;
        s_pfn      = is_fetch ? i_pfn    : d_pfn;
        s_allow    = is_fetch ? i_allow  : d_allow;
        s_prot     = is_fetch ? i_prot   : d_prot;
    end

    // Classify: identity, miss, page fault (invalid or no right), or hit.
    always_comb begin
        paddr = q_vaddr;
        prot  = PROT_ALL;
        exc   = EXC_NONE;
        if (!side_ident) begin
            if (!s_tag_eq) begin
                exc  = is_fetch ? EXC_IMISS : EXC_DMISS;
                prot = '0;
            end else if (!s_valid || !s_allow) begin
                exc  = is_fetch ? EXC_IPF : EXC_DPF;
                prot = '0;
            end else begin
                paddr = {s_pfn, q_vaddr[PAGE_BITS-1:0]};
                prot  = s_prot;
            end
        end
    end

    // Drive the response, gated by the registered request flag.
    always_comb begin
        rsp_valid  = q_valid;
        rsp_fault  = q_valid && (exc != EXC_NONE);
        rsp_hit    = q_valid && (exc == EXC_NONE);
        rsp_exc    = q_valid ? exc : EXC_NONE;
        rsp_paddr  = paddr;
        rsp_prot   = prot;
        rsv_cancel = rsp_fault;
    end

    // Error-address register: latch the virtual address of each fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_addr <= '0;
        end else if (rsp_fault) begin
            err_addr <= q_vaddr;
        end
    end
endmodule

// File: rtl/tlbx_checker.sv
// Property checker for tlb_xlate_unit, attached with bind below.
module tlbx_checker #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_fault,
    input logic [2:0]        rsp_exc,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [2:0]        rsp_prot,
    input logic [ADDR_W-1:0] err_addr,
    input logic              rsv_cancel,
    input logic [ADDR_W-1:0] q_vaddr,
    input logic              side_ident
);
    assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_fault));
    assert_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && side_ident) |-> (rsp_hit && rsp_paddr == q_vaddr && rsp_prot == 3'b111));
    assert_fault_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_exc >= 3'd1 && rsp_exc <= 3'd4));
    assert_hit_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_exc == 3'd0 && rsp_paddr[PAGE_BITS-1:0] == q_vaddr[PAGE_BITS-1:0]));
    assert_err_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |=> (err_addr == $past(q_vaddr)));
    assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_fault |=> $stable(err_addr));
    assert_rsv_with_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_cancel |-> rsp_valid && !rsp_hit);
endmodule

bind tlb_xlate_unit tlbx_checker #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_exc(rsp_exc), .rsp_paddr(rsp_paddr), .rsp_prot(rsp_prot),
    .err_addr(err_addr), .rsv_cancel(rsv_cancel),
    .q_vaddr(q_vaddr), .side_ident(side_ident)
);

// File: tb/tlb_xlate_unit_bench.sv
// Directed bench for tlb_xlate_unit: one task per scenario, each self-checking.
module tlb_xlate_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_type = '0;
    logic        req_sup = 1'b0;
    logic        imu_en = 1'b0;
    logic        dmu_en = 1'b0;
    logic        fill_en = 1'b0;
    logic        fill_inst = 1'b0;
    logic        fill_xlate = 1'b0;
    logic [5:0]  fill_idx = '0;
    logic [31:0] fill_data = '0;
    logic        rsp_valid, rsp_hit, rsp_fault, rsv_cancel;
    logic [2:0]  rsp_exc, rsp_prot;
    logic [31:0] rsp_paddr, err_addr;

    int checks = 0;
    int errors = 0;

    logic        c_valid, c_hit, c_fault, c_rsv, c_valid2;
    logic [2:0]  c_exc, c_prot;
    logic [31:0] c_paddr, c_err;

    localparam logic [1:0] T_READ = 2'b00, T_WRITE = 2'b01, T_FETCH = 2'b10;

    tlb_xlate_unit u_tlb_xlate_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_type(req_type), .req_sup(req_sup), .imu_en(imu_en), .dmu_en(dmu_en),
        .fill_en(fill_en), .fill_inst(fill_inst), .fill_xlate(fill_xlate),
        .fill_idx(fill_idx), .fill_data(fill_data), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_exc(rsp_exc),
        .rsp_paddr(rsp_paddr), .rsp_prot(rsp_prot), .err_addr(err_addr),
        .rsv_cancel(rsv_cancel)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] mword(input logic [18:0] vpn, input logic v);
        return {vpn, 12'b0, v};
    endfunction

    function automatic logic [31:0] xword(input logic [18:0] pfn, input logic [3:0] perm);
        return {pfn, 13'b0} | ({28'b0, perm} << 6);
    endfunction

    // One table write, driven at a falling edge, active for one rising edge.
    task automatic fill(input logic inst, input logic xl, input logic [5:0] idx,
                        input logic [31:0] data);
        fill_en = 1'b1; fill_inst = inst; fill_xlate = xl; fill_idx = idx; fill_data = data;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // Issue one request; capture the response and then the error address.
    task automatic do_req(input logic [31:0] va, input logic [1:0] typ, input logic sup);
        req_valid = 1'b1; req_vaddr = va; req_type = typ; req_sup = sup;
        @(negedge clk);
        c_valid = rsp_valid; c_hit = rsp_hit; c_fault = rsp_fault; c_exc = rsp_exc;
        c_paddr = rsp_paddr; c_prot = rsp_prot; c_rsv = rsv_cancel;
        req_valid = 1'b0;
        @(negedge clk);
        c_valid2 = rsp_valid; c_err = err_addr;
    endtask

    task automatic t_reset;
        check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
        check("R1 err_addr after reset", err_addr, 32'd0);
        check("R1 rsv_cancel after reset", {31'b0, rsv_cancel}, 32'd0);
    endtask

    task automatic t_identity;
        imu_en = 1'b0; dmu_en = 1'b0;
        do_req(32'h1234_5678, T_READ, 1'b0);
        check("R2 response one cycle later", {31'b0, c_valid}, 32'd1);
        check("R2 response lasts one cycle", {31'b0, c_valid2}, 32'd0);
        check("R3 identity data hit", {31'b0, c_hit}, 32'd1);
        check("R3 identity data paddr", c_paddr, 32'h1234_5678);
        check("R3 identity data prot", {29'b0, c_prot}, 32'd7);
        dmu_en = 1'b1;
        do_req(32'hDEAD_BEEF, T_FETCH, 1'b0);
        check("R3 identity fetch paddr", c_paddr, 32'hDEAD_BEEF);
        check("R3 identity fetch prot/hit", {28'b0, c_hit, c_prot}, 32'hF);
        dmu_en = 1'b0;
    endtask

    task automatic t_inst;
        logic [31:0] va;
        logic [18:0] vpn;
        va = 32'h0040_2ABC; vpn = va[31:13];
        imu_en = 1'b1;
        fill(1'b1, 1'b0, vpn[5:0], mword(vpn, 1'b1));
        fill(1'b1, 1'b1, vpn[5:0], xword(19'h5A5A5, 4'b0001));
        do_req(va, T_FETCH, 1'b1);
        check("R6 supervisor fetch hit", {31'b0, c_hit}, 32'd1);
        check("R8 fetch paddr", c_paddr, {19'h5A5A5, va[12:0]});
        check("R8 fetch prot exec only", {29'b0, c_prot}, 32'd4);
        do_req(va, T_FETCH, 1'b0);
        check("R6 user fetch page fault", {29'b0, c_exc}, 32'd3);
        check("R10 rsv_cancel on fault", {31'b0, c_rsv}, 32'd1);
        check("R10 err_addr captured", c_err, va);
        do_req(va + (32'd64 << 13), T_FETCH, 1'b1);
        check("R4 instruction miss on tag mismatch", {29'b0, c_exc}, 32'd1);
        check("R10 err_addr follows new fault", c_err, va + (32'd64 << 13));
        do_req(va, T_FETCH, 1'b1);
        check("R10 err_addr holds on hit", c_err, va + (32'd64 << 13));
        check("R10 no rsv_cancel on hit", {31'b0, c_rsv}, 32'd0);
    endtask

    task automatic t_data;
        logic [31:0] va;
        logic [18:0] vpn;
        vpn = 19'h0A3F; va = {vpn, 13'h0FF1};
        dmu_en = 1'b1;
        fill(1'b0, 1'b0, 6'd63, mword(vpn, 1'b1));
        fill(1'b0, 1'b1, 6'd63, xword(19'h7_1234, 4'b0111));
        do_req(va, T_READ, 1'b0);
        check("R7 user read hit at last slot", {31'b0, c_hit}, 32'd1);
        check("R8 data paddr", c_paddr, {19'h7_1234, va[12:0]});
        check("R8 user read prot", {29'b0, c_prot}, 32'd1);
        do_req(va, T_WRITE, 1'b0);
        check("R7 user write page fault", {29'b0, c_exc}, 32'd4);
        do_req(va, T_WRITE, 1'b1);
        check("R7 supervisor write hit", {31'b0, c_hit}, 32'd1);
        check("R8 supervisor prot rw", {29'b0, c_prot}, 32'd3);
        do_req(va ^ 32'h8000_0000, T_READ, 1'b1);
        check("R4 data miss on upper tag bit", {29'b0, c_exc}, 32'd2);
        fill(1'b0, 1'b0, 6'd63, mword(vpn, 1'b0));
        do_req(va, T_READ, 1'b1);
        check("R5 invalid entry gives page fault", {29'b0, c_exc}, 32'd4);
        fill(1'b0, 1'b0, 6'd63, mword(vpn, 1'b1));
        do_req(va, T_READ, 1'b1);
        check("R9 translate word kept by match write", c_paddr, {19'h7_1234, va[12:0]});
        imu_en = 1'b1;
        do_req(va, T_FETCH, 1'b1);
        check("R9 data fill not seen by fetch", {29'b0, c_exc}, 32'd1);
    endtask

    task automatic t_fill_timing;
        logic [31:0] va;
        va = {19'h0_0105, 13'h0123};
        dmu_en = 1'b1;
        fill(1'b0, 1'b1, 6'd5, xword(19'h3_3333, 4'b0001));
        fill_en = 1'b1; fill_inst = 1'b0; fill_xlate = 1'b0; fill_idx = 6'd5;
        fill_data = mword(19'h0_0105, 1'b1);
        req_valid = 1'b1; req_vaddr = va; req_type = T_READ; req_sup = 1'b1;
        @(negedge clk);
        fill_en = 1'b0; req_valid = 1'b0;
        check("R9 fill seen by same-edge request", {31'b0, rsp_hit}, 32'd1);
        check("R9 same-edge paddr", rsp_paddr, {19'h3_3333, va[12:0]});
        @(negedge clk);
    endtask

    task automatic t_reset_clears;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 err_addr cleared by reset", err_addr, 32'd0);
        dmu_en = 1'b1;
        do_req({19'h0A3F, 13'h0FF1}, T_READ, 1'b1);
        check("R1 valid flag cleared: fault", {31'b0, c_fault}, 32'd1);
        check("R1 valid flag cleared: no hit", {31'b0, c_hit}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rsp_valid during reset", {31'b0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identity();
        t_inst();
        t_data();
        t_fill_timing();
        t_reset_clears();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule